// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block runs beside a DRAM access controller. It owns three jobs that the controller need not track. It holds the memory idle for a start-up pause after reset. It then runs a fixed count of initialization row cycles. After that it keeps a debt of refreshes owed, adding one every refresh interval so that every row is revisited within the retention period, and it pays that debt with CAS-before-RAS cycles that it drives itself once the controller grants it the strobes. It can also put the memory into self refresh on request. On wake-up it drives both strobes high for an exit recovery time and then runs a burst refresh covering every row before it reports the memory usable again.

The controller talks to the block through a request/grant pair. `ref_req` is high only while the block is in its ready idle state and owes at least one refresh. The controller answers by raising `ref_gnt` in any cycle where `ref_req` is high. From that point `strobe_own` is high and the block pays all of its debt in back-to-back row cycles. `ref_gnt` is ignored at any other time, and the controller sees that the hand-back is complete when `strobe_own` falls. While `strobe_own` is high the controller parks write enable and output enable, treats the address as don't-care, and leaves the data bus high-impedance. `sleep_req` is sampled only in the ready idle state and wins over a pending grant. Row-address generation for RAS-only refresh lies outside this block.

Top module: `drs_refresh_sched`

## Requirements
- R1: For the first PAUSE_CYC cycles after reset release, both strobes stay high, `strobe_own` stays low, and `init_done` and `ready` stay low.
- R2: After the pause, exactly INIT_CYCLES row cycles, all of the CAS-before-RAS kind, are run. Then `init_done` and `ready` rise together. `init_done` stays high until reset.
- R3: In every block-driven row cycle, `cas_n` is low for exactly CSR_CYC cycles with `ras_n` high before `ras_n` falls. `cas_n` then stays low for CHR_CYC cycles of the low `ras_n` time, and `ras_n` is low for RAS_CYC cycles. Both strobes are then high for RP_CYC cycles.
- R4: While `ready` is high, one refresh is added to the debt every REF_INTERVAL cycles. The first is added REF_INTERVAL cycles after `ready` rises. `ref_req` is high only while `ready` is high.
- R5: A grant taken while `ref_req` is high makes the block pay its entire debt as consecutive row cycles under one `strobe_own` window. `ref_req` is low when that window closes.
- R6: The debt saturates at MAX_PEND. An interval that expires while the debt is already at MAX_PEND sets `overrun`, which then stays high until reset.
- R7: A `sleep_req` taken in the ready idle state drops `cas_n` for CSR_CYC cycles before `ras_n` falls. Both strobes are then held low for at least SR_MIN_CYC cycles, and for longer while `sleep_req` stays high.
- R8: On exit from self refresh, both strobes are high for SRX_CYC cycles. ROWS row cycles follow, and only then does `ready` return. Refresh debt from before sleep is discarded, so `ref_req` is low when `ready` returns.
- R9: `strobe_own` is high whenever either strobe output is low.
- R10: During and right after reset: `ras_n`=1, `cas_n`=1, and `ref_req`, `strobe_own`, `init_done`, `ready` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self refresh; released to leave it |
| ref_gnt | input | 1 | Controller grants the strobes; used only while `ref_req` is high |
| ref_req | output | 1 | Block owes at least one refresh and is idle |
| strobe_own | output | 1 | Block is driving the strobes; controller must stay off them |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low (the controller fans it out to both byte strobes) |
| init_done | output | 1 | Power-up pause and initialization cycles have completed |
| ready | output | 1 | Memory is usable by the controller |
| overrun | output | 1 | Sticky: a refresh interval was lost because the debt was full |

## Verification
The properties assume several things about the inputs. The controller raises `ref_gnt` only in answer to a visible `ref_req`. The parameters keep CHR_CYC below RAS_CYC, and every cycle count is at least one. The row engine is started only when it is idle or finishing, which the scheduler guarantees internally. The bench drives the grant from a process on the falling clock edge that repeats `ref_req` back as `ref_gnt`, either always or only during a directed window. It drives `sleep_req` only after draining the debt, so that every scenario starts from the ready idle state with a known debt phase.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_INIT,
    S_IDLE,
    S_REF,
    S_SR_ENTER,
    S_SR_HOLD,
    S_SR_EXIT,
    S_BURST
  } sched_state_t;

  typedef enum logic [1:0] {
    E_IDLE,
    E_SETUP,
    E_ACT,
    E_PRE
  } eng_phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine
  import drs_pkg::*;
#(
  parameter int unsigned CSR_CYC = 2,
  parameter int unsigned CHR_CYC = 3,
  parameter int unsigned RAS_CYC = 12,
  parameter int unsigned RP_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n
);

  localparam int unsigned CW = $clog2(max2(max2(CSR_CYC, RAS_CYC), RP_CYC) + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] ACT_LAST   = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST   = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] HOLD_END   = CW'(CHR_CYC);

  eng_phase_t    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= E_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        E_IDLE: begin
          if (start) begin
            phase <= E_SETUP;
            cnt   <= '0;
          end
        end
        E_SETUP: begin
          if (cnt == SETUP_LAST) begin
            phase <= E_ACT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_ACT: begin
          if (cnt == ACT_LAST) begin
            phase <= E_PRE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_PRE: begin
          if (cnt == PRE_LAST) begin
            phase <= start ? E_SETUP : E_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= E_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign idle  = (phase == E_IDLE);
  assign done  = (phase == E_PRE) && (cnt == PRE_LAST);
  assign ras_n = !(phase == E_ACT);
  assign cas_n = !((phase == E_SETUP) || ((phase == E_ACT) && (cnt < HOLD_END)));

  // R5: the scheduler only launches a cycle when the engine can accept it
  p_start_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (idle || done));

  // R3: column strobe is still low at the row strobe's falling edge
  p_cas_held_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> !cas_n);

  // R3: the row strobe falls only after the setup phase
  p_fall_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(phase) == E_SETUP));

endmodule

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
  parameter int unsigned INTERVAL = 3125,
  parameter int unsigned MAX_PEND = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             serve,
  output logic [$clog2(MAX_PEND+1)-1:0]    pending,
  output logic                             overrun
);

  localparam int unsigned IW = $clog2(INTERVAL + 1);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [IW-1:0] LAST = IW'(INTERVAL - 1);
  localparam logic [PW-1:0] CAP  = PW'(MAX_PEND);

  logic [IW-1:0] cnt;
  logic          tick;
  logic          full;

  assign tick = run && (cnt == LAST);
  assign full = (pending == CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (!run) begin
      pending <= '0;
    end else if (tick && !serve) begin
      if (!full) pending <= pending + 1'b1;
    end else if (!tick && serve) begin
      pending <= pending - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (tick && !serve && full) begin
      overrun <= 1'b1;
    end
  end

  // R5: a refresh is paid only against a debt
  p_serve_needs_debt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    serve |-> (pending != '0));

  // R6: the lost-interval flag never clears outside reset
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R6: the debt stays within its cap from one cycle to the next
  p_debt_capped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !serve |=> (pending == CAP) || !$past(run) || !run);

endmodule

// File: rtl/drs_refresh_sched.sv
module drs_refresh_sched
  import drs_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 40000,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned ROWS         = 512,
  parameter int unsigned REF_INTERVAL = 3125,
  parameter int unsigned MAX_PEND     = 4,
  parameter int unsigned SR_MIN_CYC   = 20000,
  parameter int unsigned SRX_CYC      = 22,
  parameter int unsigned CSR_CYC      = 2,
  parameter int unsigned CHR_CYC      = 3,
  parameter int unsigned RAS_CYC      = 12,
  parameter int unsigned RP_CYC       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic strobe_own,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic ready,
  output logic overrun
);

  localparam int unsigned TW = $clog2(max2(max2(PAUSE_CYC, SR_MIN_CYC), max2(SRX_CYC, CSR_CYC)) + 1);
  localparam int unsigned NW = $clog2(max2(INIT_CYCLES, ROWS) + 1);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] SR_LAST    = TW'(SR_MIN_CYC - 1);
  localparam logic [TW-1:0] SRX_LAST   = TW'(SRX_CYC - 1);
  localparam logic [TW-1:0] ENTER_LAST = TW'(CSR_CYC - 1);
  localparam logic [NW-1:0] INIT_N     = NW'(INIT_CYCLES);
  localparam logic [NW-1:0] ROWS_N     = NW'(ROWS);

  sched_state_t  state;
  logic [TW-1:0] tcnt;
  logic [NW-1:0] issued;

  logic          eng_start, eng_idle, eng_done, eng_ras_n, eng_cas_n, eng_free;
  logic          want;
  logic          serve;
  logic [PW-1:0] pending;

  drs_cbr_engine #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .RP_CYC (RP_CYC)
  ) u_engine (
    .clk  (clk),
    .rst_n(rst_n),
    .start(eng_start),
    .idle (eng_idle),
    .done (eng_done),
    .ras_n(eng_ras_n),
    .cas_n(eng_cas_n)
  );

  drs_interval_timer #(
    .INTERVAL(REF_INTERVAL),
    .MAX_PEND(MAX_PEND)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ready),
    .serve  (serve),
    .pending(pending),
    .overrun(overrun)
  );

  always_comb begin
    unique case (state)
      S_INIT:  want = (issued < INIT_N);
      S_BURST: want = (issued < ROWS_N);
      S_REF:   want = (pending != '0);
      default: want = 1'b0;
    endcase
  end

  assign eng_free  = eng_idle || eng_done;
  assign eng_start = want && eng_free;
  assign serve     = (state == S_REF) && eng_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_PAUSE;
      tcnt      <= '0;
      issued    <= '0;
      init_done <= 1'b0;
    end else begin
      unique case (state)
        S_PAUSE: begin
          if (tcnt == PAUSE_LAST) begin
            state  <= S_INIT;
            tcnt   <= '0;
            issued <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_INIT: begin
          if (eng_start) issued <= issued + 1'b1;
          if (eng_idle && !want) begin
            state     <= S_IDLE;
            init_done <= 1'b1;
          end
        end
        S_IDLE: begin
          if (sleep_req) begin
            state <= S_SR_ENTER;
            tcnt  <= '0;
          end else if (ref_req && ref_gnt) begin
            state <= S_REF;
          end
        end
        S_REF: begin
          if (eng_idle && !eng_start) state <= S_IDLE;
        end
        S_SR_ENTER: begin
          if (tcnt == ENTER_LAST) begin
            state <= S_SR_HOLD;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SR_HOLD: begin
          if ((tcnt == SR_LAST) && !sleep_req) begin
            state <= S_SR_EXIT;
            tcnt  <= '0;
          end else if (tcnt != SR_LAST) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SR_EXIT: begin
          if (tcnt == SRX_LAST) begin
            state  <= S_BURST;
            tcnt   <= '0;
            issued <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_BURST: begin
          if (eng_start) issued <= issued + 1'b1;
          if (eng_idle && !want) state <= S_IDLE;
        end
        default: state <= S_PAUSE;
      endcase
    end
  end

  logic sr_cas, sr_ras;
  assign sr_cas = (state == S_SR_ENTER) || (state == S_SR_HOLD);
  assign sr_ras = (state == S_SR_HOLD);

  assign ras_n      = eng_ras_n && !sr_ras;
  assign cas_n      = eng_cas_n && !sr_cas;
  assign ready      = (state == S_IDLE) || (state == S_REF);
  assign ref_req    = (state == S_IDLE) && (pending != '0);
  assign strobe_own = !((state == S_PAUSE) || (state == S_IDLE) ||
                        ((state == S_REF) && eng_idle && !eng_start));

  // R1: no strobe activity during the start-up pause
  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAUSE) |-> (ras_n && cas_n && !init_done && !ready));

  // R2: usable only after initialization, which is never undone
  p_ready_needs_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> init_done);
  p_init_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3: column strobe leads every row strobe fall
  p_cas_leads_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  // R4: requests appear only while the memory is usable
  p_req_only_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready);

  // R7: self refresh is left only after the minimum hold
  p_sr_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && (state == S_SR_EXIT) |-> ($past(tcnt) == SR_LAST));

  // R9: the block owns the strobes whenever it pulls one low
  p_own_when_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> strobe_own);

endmodule

// File: tb/drs_refresh_sched_test.sv
`timescale 1ns/1ps
module drs_refresh_sched_test;

  localparam int PAUSE = 300;
  localparam int INITN = 8;
  localparam int ROWS  = 16;
  localparam int INTV  = 200;
  localparam int MAXP  = 3;
  localparam int SRMIN = 150;
  localparam int SRX   = 6;
  localparam int CSR   = 2;
  localparam int CHR   = 3;
  localparam int RASC  = 12;
  localparam int RP    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, strobe_own, ras_n, cas_n, init_done, ready, overrun;

  always #2.5 clk = ~clk;

  drs_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .ROWS(ROWS), .REF_INTERVAL(INTV),
    .MAX_PEND(MAXP), .SR_MIN_CYC(SRMIN), .SRX_CYC(SRX), .CSR_CYC(CSR),
    .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n),
    .init_done(init_done), .ready(ready), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // grant driver: echoes ref_req when enabled
  bit auto_gnt  = 1'b0;
  bit force_gnt = 1'b0;
  always @(negedge clk) ref_gnt <= (auto_gnt || force_gnt) && ref_req;

  // port monitor, sampled away from the active edge
  int cyc = 0, falls = 0, first_fall = -1;
  int lead = 0, rlen = 0, hold = 0;
  bit hold_run = 1'b0;
  int min_lead = 1000000, min_rlen = 1000000, min_hold = 1000000, max_rlen = 0;
  int ready_rise = -1, req_rises = 0, req_rise_a = -1, req_rise_b = -1;
  int req_bad = 0, own_bad = 0;
  logic p_ras = 1'b1, p_ready = 1'b0, p_req = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_ras && !ras_n) begin
        falls++;
        if (first_fall < 0) first_fall = cyc;
        if (lead < min_lead) min_lead = lead;
        rlen = 1; hold = cas_n ? 0 : 1; hold_run = !cas_n;
      end else if (!ras_n) begin
        rlen++;
        if (hold_run && !cas_n) hold++; else hold_run = 1'b0;
      end else if (!p_ras && ras_n) begin
        if (rlen < min_rlen) min_rlen = rlen;
        if (rlen > max_rlen) max_rlen = rlen;
        if (hold < min_hold) min_hold = hold;
      end
      if (ras_n && !cas_n) lead++; else if (ras_n) lead = 0;
      if (!p_ready && ready) ready_rise = cyc;
      if (!p_req && ref_req) begin
        req_rises++; req_rise_a = req_rise_b; req_rise_b = cyc;
      end
      if (ref_req && !ready) req_bad++;
      if ((!ras_n || !cas_n) && !strobe_own) own_bad++;
      p_ras = ras_n; p_ready = ready; p_req = ref_req;
    end
  end

  task automatic wait_until_ready(input bit lvl);
    for (int i = 0; i < 20000 && (ready != lvl); i++) @(negedge clk);
  endtask

  task automatic drain();
    auto_gnt = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20000 && !(!ref_req && !strobe_own && ready && !ref_gnt); i++)
      @(negedge clk);
    auto_gnt = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 20000 && !ref_req; i++) @(negedge clk);
  endtask

  task automatic grant_window(output int paid);
    int f0;
    f0 = falls;
    force_gnt = 1'b1;
    for (int i = 0; i < 100 && !strobe_own; i++) @(negedge clk);
    force_gnt = 1'b0;
    for (int i = 0; i < 20000 && strobe_own; i++) @(negedge clk);
    paid = falls - f0;
  endtask

  task automatic t_reset();
    // R10: values held in reset and just after release
    check(ras_n === 1'b1 && cas_n === 1'b1, "R10", "strobes in reset", {ras_n, cas_n}, 3);
    check(ref_req === 1'b0 && strobe_own === 1'b0, "R10", "req/own in reset",
          {ref_req, strobe_own}, 0);
    check(init_done === 1'b0 && ready === 1'b0 && overrun === 1'b0, "R10",
          "init/ready/overrun in reset", {init_done, ready, overrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && !ready && !strobe_own, "R10", "after release",
          {ras_n, cas_n, ready, strobe_own}, 4'b1100);
  endtask

  task automatic t_init();
    for (int i = 0; i < 20000 && !init_done; i++) @(negedge clk);
    check(first_fall >= PAUSE, "R1", "first row strobe cycle", first_fall, PAUSE);
    check(falls == INITN, "R2", "init row cycles", falls, INITN);
    check(ready == 1'b1, "R2", "ready with init_done", ready, 1);
    check(min_lead == CSR, "R3", "cas lead cycles", min_lead, CSR);
    check(min_hold == CHR, "R3", "cas hold after fall", min_hold, CHR);
    check(min_rlen == RASC, "R3", "ras low cycles", min_rlen, RASC);
  endtask

  task automatic t_periodic();
    int f0, r0;
    r0 = req_rises;
    f0 = falls;
    auto_gnt = 1'b1;
    for (int i = 0; i < 20000 && req_rises < r0 + 2; i++) @(negedge clk);
    check(req_rise_a - ready_rise == INTV, "R4", "first request delay",
          req_rise_a - ready_rise, INTV);
    check(req_rise_b - req_rise_a == INTV, "R4", "request spacing",
          req_rise_b - req_rise_a, INTV);
    for (int i = 0; i < 100 && strobe_own; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    check(falls - f0 == 2, "R4", "one refresh per interval", falls - f0, 2);
    auto_gnt = 1'b0;
  endtask

  task automatic t_back_to_back();
    int paid;
    drain();
    wait_req();
    repeat (INTV + INTV / 2) @(negedge clk);
    check(overrun == 1'b0 && ref_req == 1'b1, "R5", "two owed, no overrun",
          {overrun, ref_req}, 1);
    grant_window(paid);
    check(paid == 2, "R5", "back-to-back cycles in one window", paid, 2);
    check(ref_req == 1'b0, "R5", "request low after window", ref_req, 0);
  endtask

  task automatic t_overrun();
    int paid;
    drain();
    wait_req();
    repeat (2 * INTV + INTV / 2) @(negedge clk);
    check(overrun == 1'b0, "R6", "no overrun at cap", overrun, 0);
    repeat (INTV) @(negedge clk);
    check(overrun == 1'b1, "R6", "overrun after lost interval", overrun, 1);
    grant_window(paid);
    check(paid == MAXP, "R6", "debt saturated at cap", paid, MAXP);
    repeat (INTV) @(negedge clk);
    check(overrun == 1'b1, "R6", "overrun sticky", overrun, 1);
  endtask

  task automatic t_sleep_short();
    int f0;
    drain();
    f0 = falls;
    max_rlen = 0;
    sleep_req = 1'b1;
    repeat (4) @(negedge clk);
    sleep_req = 1'b0;
    check(ready == 1'b0, "R7", "ready drops on sleep", ready, 0);
    wait_until_ready(1'b1);
    check(max_rlen == SRMIN, "R7", "minimum self-refresh hold", max_rlen, SRMIN);
    check(falls - f0 == 1 + ROWS, "R8", "burst rows before ready", falls - f0, 1 + ROWS);
    check(min_lead == CSR, "R7", "cas leads ras on entry", min_lead, CSR);
    @(negedge clk);
    check(ref_req == 1'b0, "R8", "old debt discarded", ref_req, 0);
  endtask

  task automatic t_sleep_long();
    drain();
    max_rlen = 0;
    sleep_req = 1'b1;
    repeat (2 * SRMIN + 20) @(negedge clk);
    sleep_req = 1'b0;
    wait_until_ready(1'b1);
    check(max_rlen >= 2 * SRMIN, "R7", "hold follows sleep_req", max_rlen, 2 * SRMIN);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_init();
    t_periodic();
    t_back_to_back();
    t_overrun();
    t_sleep_short();
    t_sleep_long();
    check(own_bad == 0, "R9", "strobe low without ownership", own_bad, 0);
    check(req_bad == 0, "R4", "request while not ready", req_bad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule